// File: doc/BRIEF.md
# Chained FIFO Depth Token Controller

This block sits beside the memory of one FIFO device and decides when that device may take a write and when it may supply a read. Several identical devices can be joined in a ring to act as one deeper FIFO. Each device owns the write side and the read side only while it holds the matching token. A device passes its write token on by emitting a one-cycle pulse after it writes its final physical location, and it passes its read token the same way after it reads its final location. The neighbour picks up a pulse on its expansion input at the next rising edge of the matching clock. Words therefore fill one device after another and are drained in the same order.

A static mode strap selects between the ring and standalone use. In standalone use the device owns both ports permanently. Its write-expansion output then carries the local half-full indication, and its read-expansion output stays low. In the ring, a first-load strap marks the device that starts with both tokens. Every other device starts with neither token.

The local FIFO supplies two level signals: one says the next write targets the last physical slot, and the other says the next read does. The controller combines these with its gates to detect a handoff. The write side runs entirely on the write clock and the read side entirely on the read clock.

Top module: `depth_chain_ctl`

## Requirements
- R1: With `chain_mode` low, `local_wr_en` equals `wr_req` and `local_rd_en` equals `rd_req` at all times, regardless of the expansion inputs.
- R2: With `chain_mode` low, `wx_out` follows the `half_full` input (high means more than half full) and `rx_out` stays low.
- R3: With `chain_mode` high, during and just after reset a device with `first_load` low holds both tokens and a device with `first_load` high holds neither. While reset is active, `wx_out` and `rx_out` are low.
- R4: With `chain_mode` high, a write-clock edge where `local_wr_en` and `wr_at_end` are both high drops the write token at that edge and raises `wx_out` for the following write-clock cycle.
- R5: With `chain_mode` high, a read-clock edge where `local_rd_en` and `rd_at_end` are both high drops the read token at that edge and raises `rx_out` for the following read-clock cycle.
- R6: With `chain_mode` high, a write-clock edge that samples `wx_in` high gives the device the write token. A read-clock edge that samples `rx_in` high gives it the read token.
- R7: Each expansion pulse in ring mode lasts exactly one cycle of its clock.
- R8: With `chain_mode` high, `local_wr_en` is `wr_req` gated by the write token and `local_rd_en` is `rd_req` gated by the read token. A request made without the token has no effect.
- R9: In a ring of devices, exactly one token of each kind exists at any time: either one device holds it or one pulse carries it. Words read from the ring come out in the order they were written, across device boundaries.
- R10: With `chain_mode` high, `wr_at_end` or `rd_at_end` without an accepted access produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| chain_mode | input | 1 | Static strap: 1 selects ring operation, 0 selects standalone |
| first_load | input | 1 | Static strap: 0 marks the device that starts with both tokens |
| wx_in | input | 1 | Write token pulse from the previous device |
| rx_in | input | 1 | Read token pulse from the previous device |
| wr_req | input | 1 | Write request from the shared write port |
| rd_req | input | 1 | Read request from the shared read port |
| wr_at_end | input | 1 | Local FIFO: the next write targets the last physical slot |
| rd_at_end | input | 1 | Local FIFO: the next read targets the last physical slot |
| half_full | input | 1 | Local FIFO: more than half full (standalone mode only) |
| local_wr_en | output | 1 | Write enable to the local FIFO |
| local_rd_en | output | 1 | Read enable to the local FIFO |
| wx_out | output | 1 | Write token pulse to the next device, or half-full in standalone mode |
| rx_out | output | 1 | Read token pulse to the next device |

## Verification
The hardest situation to reach is the ring reaching its total capacity, with the write token returned to the first device while that device still holds unread words. The behaviour here depends on read ordering across all three devices at once. The stimulus reaches it with a directed write-only burst that fills all three small local FIFOs, followed by a read-only drain. A long stretch of seeded random traffic then runs on two offset clocks, so that tokens cross device boundaries many times and handoff cycles coincide with new requests. A final drain confirms that every word came back in write order.

// File: rtl/depth_chain_ctl.sv
module depth_chain_ctl (
  input  logic wclk,
  input  logic rclk,
  input  logic rst_n,
  input  logic chain_mode,
  input  logic first_load,
  input  logic wx_in,
  input  logic rx_in,
  input  logic wr_req,
  input  logic rd_req,
  input  logic wr_at_end,
  input  logic rd_at_end,
  input  logic half_full,
  output logic local_wr_en,
  output logic local_rd_en,
  output logic wx_out,
  output logic rx_out
);

  logic wtok, rtok;
  logic wpulse, rpulse;
  logic w_hand, r_hand;

  assign local_wr_en = wr_req & (~chain_mode | wtok);
  assign local_rd_en = rd_req & (~chain_mode | rtok);

  assign w_hand = chain_mode & local_wr_en & wr_at_end;
  assign r_hand = chain_mode & local_rd_en & rd_at_end;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wtok   <= ~first_load;
      wpulse <= 1'b0;
    end else begin
      wpulse <= w_hand;
      if (chain_mode & wx_in)
        wtok <= 1'b1;
      else if (w_hand)
        wtok <= 1'b0;
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rtok   <= ~first_load;
      rpulse <= 1'b0;
    end else begin
      rpulse <= r_hand;
      if (chain_mode & rx_in)
        rtok <= 1'b1;
      else if (r_hand)
        rtok <= 1'b0;
    end
  end

  assign wx_out = chain_mode ? wpulse : half_full;
  assign rx_out = chain_mode & rpulse;

endmodule

// File: rtl/depth_chain_ctl_sva.sv
module depth_chain_ctl_sva (
  input logic wclk,
  input logic rclk,
  input logic rst_n,
  input logic chain_mode,
  input logic first_load,
  input logic wx_in,
  input logic rx_in,
  input logic wr_req,
  input logic rd_req,
  input logic wr_at_end,
  input logic rd_at_end,
  input logic half_full,
  input logic local_wr_en,
  input logic local_rd_en,
  input logic wx_out,
  input logic rx_out
);

  assert_solo_gate_R1: assert property (@(posedge wclk) disable iff (!rst_n)
    (!chain_mode && wr_req) |-> local_wr_en);

  assert_solo_quiet_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    !chain_mode |-> !rx_out);

  assert_wr_pulse_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    (chain_mode && local_wr_en && wr_at_end) |=> wx_out);

  assert_rd_pulse_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    (chain_mode && local_rd_en && rd_at_end) |=> rx_out);

  assert_wr_take_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    (chain_mode && wx_in) |=> (!wr_req || local_wr_en));

  assert_rd_take_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    (chain_mode && rx_in) |=> (!rd_req || local_rd_en));

  assert_wr_width_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    (chain_mode && wx_out) |=> !wx_out);

  assert_rd_width_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    (chain_mode && rx_out) |=> !rx_out);

  assert_wr_release_R8: assert property (@(posedge wclk) disable iff (!rst_n)
    (chain_mode && local_wr_en && wr_at_end && !wx_in) |=> !local_wr_en);

  assert_wr_quiet_R10: assert property (@(posedge wclk) disable iff (!rst_n)
    (chain_mode && !local_wr_en) |=> !wx_out);

  assert_rd_quiet_R10: assert property (@(posedge rclk) disable iff (!rst_n)
    (chain_mode && !local_rd_en) |=> !rx_out);

endmodule

bind depth_chain_ctl depth_chain_ctl_sva u_sva (.*);

// File: tb/depth_chain_ctl_bench.sv
module depth_chain_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 3;
  localparam int SLOTS = 4;
  localparam int CAP = NDEV * SLOTS;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [15:0] wdata = '0, wdata_s = '0;
  logic [2:0] lwe, lrd, wxo, rxo, wend, rend;
  logic [2:0] lwe_s = '0, lrd_s = '0, wexp = '0, rexp = '0, wxo_prev = '0, rxo_prev = '0;
  logic [15:0] mem [NDEV][SLOTS];
  int wp [NDEV];
  int rp [NDEV];
  logic [15:0] expq [$];
  int phase = 0;
  int n_checks = 0, n_fail = 0, n_reads = 0, n_writes = 0;
  bit done = 0;

  logic s_wr = 1'b0, s_rd = 1'b0, s_hf = 1'b0, s_we, s_re, s_wx, s_rx;

  initial forever #(CLK_PERIOD/2) wclk = ~wclk;
  initial begin #3; forever #(CLK_PERIOD/2) rclk = ~rclk; end

  always_comb for (int d = 0; d < NDEV; d++) begin
    wend[d] = (wp[d] == SLOTS-1);
    rend[d] = (rp[d] == SLOTS-1);
  end

  for (genvar i = 0; i < NDEV; i++) begin : g_ring
    depth_chain_ctl u_depth_chain_ctl (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
      .chain_mode(1'b1), .first_load(i != 0),
      .wx_in(wxo[(i+NDEV-1)%NDEV]), .rx_in(rxo[(i+NDEV-1)%NDEV]),
      .wr_req(wr_req), .rd_req(rd_req),
      .wr_at_end(wend[i]), .rd_at_end(rend[i]), .half_full(1'b0),
      .local_wr_en(lwe[i]), .local_rd_en(lrd[i]),
      .wx_out(wxo[i]), .rx_out(rxo[i]));
  end

  depth_chain_ctl u_depth_chain_ctl_solo (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .chain_mode(1'b0), .first_load(1'b0),
    .wx_in(1'b0), .rx_in(1'b0),
    .wr_req(s_wr), .rd_req(s_rd),
    .wr_at_end(1'b1), .rd_at_end(1'b1), .half_full(s_hf),
    .local_wr_en(s_we), .local_rd_en(s_re),
    .wx_out(s_wx), .rx_out(s_rx));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // write side stimulus and sampling
  always @(negedge wclk) if (rst_n && phase != 0) begin
    wr_req = (phase == 1 || (phase == 3 && $urandom_range(99) < 60)) && (expq.size() < CAP);
    wdata  = 16'($urandom);
    s_wr   = 1'($urandom);
    s_hf   = 1'($urandom);
    #1;
    lwe_s = lwe; wdata_s = wdata;
    if (wr_req)
      check($countones(lwe) + $countones(wxo) == 1, "R9", "write token count",
            $countones(lwe) + $countones(wxo), 1);
    check(wxo == wexp, "R4/R10", "write pulse pattern", int'(wxo), int'(wexp));
    check((wxo & wxo_prev) == 3'b000, "R7", "write pulse width", int'(wxo & wxo_prev), 0);
    wxo_prev = wxo;
    check(s_we == s_wr, "R1", "solo write gate", s_we, s_wr);
    check(s_wx == s_hf, "R2", "solo half-full out", s_wx, s_hf);
  end

  always @(posedge wclk) if (rst_n) begin
    for (int d = 0; d < NDEV; d++) begin
      if (lwe_s[d]) begin
        mem[d][wp[d]] <= wdata_s;
        wp[d] <= (wp[d] + 1) % SLOTS;
        wexp[d] <= (wp[d] == SLOTS-1);
        expq.push_back(wdata_s);
        n_writes++;
      end else
        wexp[d] <= 1'b0;
    end
  end

  // read side stimulus and sampling
  always @(negedge rclk) if (rst_n && phase != 0) begin
    rd_req = (phase == 2 || phase == 4 || (phase == 3 && $urandom_range(99) < 50)) && (expq.size() > 0);
    s_rd   = 1'($urandom);
    #1;
    lrd_s = lrd;
    if (rd_req)
      check($countones(lrd) + $countones(rxo) == 1, "R9", "read token count",
            $countones(lrd) + $countones(rxo), 1);
    check(rxo == rexp, "R5/R10", "read pulse pattern", int'(rxo), int'(rexp));
    check((rxo & rxo_prev) == 3'b000, "R7", "read pulse width", int'(rxo & rxo_prev), 0);
    rxo_prev = rxo;
    check(s_re == s_rd, "R1", "solo read gate", s_re, s_rd);
    check(s_rx == 1'b0, "R2", "solo read pulse", s_rx, 0);
  end

  always @(posedge rclk) if (rst_n) begin
    for (int d = 0; d < NDEV; d++) begin
      if (lrd_s[d]) begin
        logic [15:0] want;
        want = (expq.size() > 0) ? expq.pop_front() : 16'hxxxx;
        check(mem[d][rp[d]] === want, "R9", "read data order", int'(mem[d][rp[d]]), int'(want));
        rp[d] <= (rp[d] + 1) % SLOTS;
        rexp[d] <= (rp[d] == SLOTS-1);
        n_reads++;
      end else
        rexp[d] <= 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge wclk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < NDEV; d++) begin wp[d] = 0; rp[d] = 0; end
    wr_req = 1'b1; rd_req = 1'b1; s_wr = 1'b1; s_rd = 1'b0;
    #(2*CLK_PERIOD + 1);
    check(lwe == 3'b001, "R3", "write owners in reset", int'(lwe), 1);
    check(lrd == 3'b001, "R3", "read owners in reset", int'(lrd), 1);
    check(wxo == 3'b000 && rxo == 3'b000, "R3", "pulses in reset", int'({wxo, rxo}), 0);
    check(s_we == 1'b1 && s_re == 1'b0, "R1", "solo gates in reset", int'({s_we, s_re}), 2);
    @(negedge wclk);
    wr_req = 1'b0; rd_req = 1'b0;
    rst_n = 1'b1;
    #1;
    wr_req = 1'b1;
    #1;
    check(lwe == 3'b001, "R3", "write owner after reset", int'(lwe), 1);
    wr_req = 1'b0;
    // directed: fill the whole ring, then drain it
    phase = 1;
    repeat (CAP + 8) @(posedge wclk);
    check(expq.size() == CAP, "R9", "ring filled to capacity", expq.size(), CAP);
    phase = 2;
    for (int k = 0; k < 200 && expq.size() > 0; k++) @(posedge rclk);
    check(expq.size() == 0, "R9", "ring drained", expq.size(), 0);
    // seeded random traffic
    phase = 3;
    repeat (4000) @(posedge wclk);
    phase = 4;
    for (int k = 0; k < 400 && expq.size() > 0; k++) @(posedge rclk);
    repeat (4) @(posedge rclk);
    phase = 0;
    check(expq.size() == 0, "R9", "final drain", expq.size(), 0);
    check(n_reads == n_writes, "R9", "reads equal writes", n_reads, n_writes);
    check(n_writes > 10*CAP, "R6", "tokens circulated", n_writes, 10*CAP);
    finish_run();
  end
endmodule